// File: doc/BRIEF.md
# Packet Byte FIFO with Status Flags

This block is the data buffer between a packet radio's modem side and its register bus. It stores bytes in first-in, first-out order, 66 of them at most. It keeps a set of status flags that software polls or routes to interrupts. The transmit path writes payload bytes in and the modem reads them out. On receive the roles swap. The packet engine and the CRC unit report their results to this block as single-cycle strobes.

The FIFO-state flags are full, not-empty and above-level. The above-level flag compares the stored count with a programmable threshold. An overrun flag records a write that found the FIFO full. Writing one to the overrun flag's clear input flushes all stored data and drops every flag in one cycle, so the next packet can start at once. Three packet flags depend on the radio mode and on the FIFO contents:

- **Packet sent** holds only while the radio stays in transmit.
- **Payload ready** clears by itself once the FIFO drains to empty.
- **CRC good** also clears by itself once the FIFO drains to empty.

Top module: `pkt_fifo_status`

## Requirements
- R1: After reset every flag output is 0 and rd_data is 0x00.
- R2: Bytes are read back in the order they were written; rd_data shows the byte one cycle after the read cycle; the FIFO holds up to 66 bytes.
- R3: full is 1 exactly when 66 bytes are stored, and 0 with 65 stored.
- R4: not_empty is 1 whenever at least one byte is stored.
- R5: above_level is 1 only when the stored count is strictly greater than level_thresh; a count equal to the threshold leaves it 0.
- R6: A write with no read in the same cycle while 66 bytes are stored is discarded and leaves the stored bytes unchanged. If the mode is not sleep, it also sets overrun.
- R7: Mode encoding is 2'b00 sleep, 2'b01 standby, 2'b10 transmit, 2'b11 receive; a discarded write in sleep mode leaves overrun at 0.
- R8: A cycle with ovr_clr_wr=1 and ovr_clr_bit=1 empties the FIFO and clears all flags on the next cycle. With ovr_clr_bit=0 the write has no effect.
- R9: pkt_sent sets when tx_done_stb arrives in transmit mode, ignores the strobe in other modes, and clears once the mode is not transmit.
- R10: In receive mode rx_last_stb sets payload_ready when crc_pass_stb is high in the same cycle. It also sets payload_ready, with no good CRC, when crc_check_en=0 or crc_autoclr_off=1.
- R11: crc_ok sets when crc_pass_stb arrives in receive mode.
- R12: payload_ready and crc_ok clear when the FIFO becomes empty.
- R13: A read from an empty FIFO returns 0x00 and does not move the read position.
- R14: A read and a write in the same cycle on a FIFO that is neither empty nor full leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write a byte this cycle |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read a byte this cycle |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |
| level_thresh | input | 7 | Count threshold for above_level |
| ovr_clr_wr | input | 1 | Register write to the overrun flag |
| ovr_clr_bit | input | 1 | Value written; 1 flushes and clears |
| mode | input | 2 | Radio mode (00 sleep, 01 standby, 10 tx, 11 rx) |
| crc_check_en | input | 1 | CRC checking enabled |
| crc_autoclr_off | input | 1 | Payload ready does not wait for a good CRC |
| tx_done_stb | input | 1 | Whole packet transmitted |
| rx_last_stb | input | 1 | Last payload byte received |
| crc_pass_stb | input | 1 | Payload CRC good |
| full | output | 1 | 66 bytes stored |
| not_empty | output | 1 | At least one byte stored |
| above_level | output | 1 | Count greater than level_thresh |
| overrun | output | 1 | A write was lost to a full FIFO |
| pkt_sent | output | 1 | Packet transmitted |
| payload_ready | output | 1 | Received payload ready |
| crc_ok | output | 1 | Received CRC good |

## Verification
The assertions check several relations on every cycle:

- full or either receive flag always implies not_empty.
- A full FIFO stays full under a lone write.
- Sleep mode never raises overrun.
- Leaving transmit always drops pkt_sent.
- A flush leaves every flag at zero.
- A full FIFO with a steady threshold below 66 always shows above_level.

Some behaviours only the bench scenarios can show. These are the byte order through a wrap of the storage, and that an overrun leaves the stored bytes intact. They also include the exact threshold boundary, the count staying the same under a simultaneous read and write, and the three ways payload_ready can be gated by CRC settings.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_TX    = 2'd2,
    MODE_RX    = 2'd3
  } radio_mode_e;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/pkt_fifo_mem.sv
// Simple dual-port storage, read-first, registered read port with
// synchronous clear so it maps onto a block RAM output register.
module pkt_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 66,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  input  logic              zero_rd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (re)      rdata <= store[raddr];
    else if (zero_rd) rdata <= '0;
  end
endmodule

// File: rtl/pkt_fifo_ctrl.sv
// Pointer and occupancy control; decides which accesses are accepted.
module pkt_fifo_ctrl #(
  parameter int DEPTH = 66,
  parameter int AW    = 7,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          flush,
  input  logic          sleep,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          zero_rd,
  output logic [CW-1:0] count_nxt,
  output logic          overrun_evt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          is_full, is_empty, rd_ok, wr_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    is_full     = (count == FULL_CNT);
    is_empty    = (count == '0);
    rd_ok       = rd_en && !flush && !is_empty;
    wr_ok       = wr_en && !flush && (!is_full || rd_ok);
    overrun_evt = wr_en && !flush && is_full && !rd_ok && !sleep;
    zero_rd     = rd_en && !flush && is_empty;
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(wr_ok) - CW'(rd_ok);
  end

  assign mem_we    = wr_ok;
  assign mem_waddr = wptr;
  assign mem_re    = rd_ok;
  assign mem_raddr = rptr;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/pkt_fifo_flags.sv
// Registered status flags derived from next occupancy and event strobes.
module pkt_fifo_flags
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] level_thresh,
  input  logic          flush,
  input  logic          overrun_evt,
  input  radio_mode_e   mode,
  input  logic          crc_check_en,
  input  logic          crc_autoclr_off,
  input  logic          tx_done_stb,
  input  logic          rx_last_stb,
  input  logic          crc_pass_stb,
  output logic          full,
  output logic          not_empty,
  output logic          above_level,
  output logic          overrun,
  output logic          pkt_sent,
  output logic          payload_ready,
  output logic          crc_ok
);
  logic in_rx, drains, pay_set, crc_set;

  always_comb begin
    in_rx   = (mode == MODE_RX);
    drains  = flush || (count_nxt == '0);
    pay_set = in_rx && rx_last_stb &&
              (crc_pass_stb || !crc_check_en || crc_autoclr_off);
    crc_set = in_rx && crc_pass_stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full          <= 1'b0;
      not_empty     <= 1'b0;
      above_level   <= 1'b0;
      overrun       <= 1'b0;
      pkt_sent      <= 1'b0;
      payload_ready <= 1'b0;
      crc_ok        <= 1'b0;
    end else begin
      full        <= (count_nxt == CW'(DEPTH));
      not_empty   <= (count_nxt != '0);
      above_level <= (count_nxt > level_thresh);

      if (flush)            overrun <= 1'b0;
      else if (overrun_evt) overrun <= 1'b1;

      if (flush || mode != MODE_TX) pkt_sent <= 1'b0;
      else if (tx_done_stb)         pkt_sent <= 1'b1;

      if (drains)       payload_ready <= 1'b0;
      else if (pay_set) payload_ready <= 1'b1;

      if (drains)       crc_ok <= 1'b0;
      else if (crc_set) crc_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_fifo_status.sv
module pkt_fifo_status
  import pkt_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 66,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CW-1:0]     level_thresh,
  input  logic              ovr_clr_wr,
  input  logic              ovr_clr_bit,
  input  logic [1:0]        mode,
  input  logic              crc_check_en,
  input  logic              crc_autoclr_off,
  input  logic              tx_done_stb,
  input  logic              rx_last_stb,
  input  logic              crc_pass_stb,
  output logic              full,
  output logic              not_empty,
  output logic              above_level,
  output logic              overrun,
  output logic              pkt_sent,
  output logic              payload_ready,
  output logic              crc_ok
);
  localparam int AW = ptr_width(DEPTH);

  radio_mode_e   mode_e;
  logic          flush, sleep;
  logic          mem_we, mem_re, zero_rd, overrun_evt;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [CW-1:0] count_nxt;

  assign mode_e = radio_mode_e'(mode);
  assign flush  = ovr_clr_wr && ovr_clr_bit;
  assign sleep  = (mode_e == MODE_SLEEP);

  pkt_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk, .rst, .wr_en, .rd_en, .flush, .sleep,
    .mem_we, .mem_waddr, .mem_re, .mem_raddr, .zero_rd,
    .count_nxt, .overrun_evt
  );

  pkt_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk, .rst, .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .re(mem_re), .raddr(mem_raddr), .zero_rd, .rdata(rd_data)
  );

  pkt_fifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk, .rst, .count_nxt, .level_thresh, .flush, .overrun_evt,
    .mode(mode_e), .crc_check_en, .crc_autoclr_off,
    .tx_done_stb, .rx_last_stb, .crc_pass_stb,
    .full, .not_empty, .above_level, .overrun, .pkt_sent,
    .payload_ready, .crc_ok
  );
endmodule

// File: rtl/pkt_fifo_status_chk.sv
module pkt_fifo_status_chk #(
  parameter int DEPTH = 66,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] level_thresh,
  input logic          ovr_clr_wr,
  input logic          ovr_clr_bit,
  input logic [1:0]    mode,
  input logic          full,
  input logic          not_empty,
  input logic          above_level,
  input logic          overrun,
  input logic          pkt_sent,
  input logic          payload_ready,
  input logic          crc_ok
);
  logic clr;
  assign clr = ovr_clr_wr && ovr_clr_bit;

  a_r3_full_implies_data: assert property (@(posedge clk) disable iff (rst)
    full |-> not_empty);

  a_r12_payload_needs_data: assert property (@(posedge clk) disable iff (rst)
    payload_ready |-> not_empty);

  a_r12_crc_needs_data: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> not_empty);

  a_r6_full_holds_on_write: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !clr) |=> full);

  a_r7_no_overrun_in_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !overrun) |=> !overrun);

  a_r9_sent_only_in_tx: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b10) |=> !pkt_sent);

  a_r8_clear_flushes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!not_empty && !full && !overrun && !pkt_sent &&
             !payload_ready && !crc_ok && !above_level));

  a_r5_full_above_level: assert property (@(posedge clk) disable iff (rst)
    (full && $stable(level_thresh) && level_thresh < CW'(DEPTH)) |-> above_level);
endmodule

bind pkt_fifo_status pkt_fifo_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .level_thresh(level_thresh), .ovr_clr_wr(ovr_clr_wr),
  .ovr_clr_bit(ovr_clr_bit), .mode(mode), .full(full),
  .not_empty(not_empty), .above_level(above_level), .overrun(overrun),
  .pkt_sent(pkt_sent), .payload_ready(payload_ready), .crc_ok(crc_ok)
);

// File: tb/pkt_fifo_status_test.sv
`timescale 1ns/1ps
module pkt_fifo_status_test;
  localparam int DEPTH = 66;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, rd_en = 0, ovr_clr_wr = 0, ovr_clr_bit = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [6:0] level_thresh = 7'd4;
  logic [1:0] mode = 2'b11;
  logic       crc_check_en = 1, crc_autoclr_off = 0;
  logic       tx_done_stb = 0, rx_last_stb = 0, crc_pass_stb = 0;
  logic       full, not_empty, above_level, overrun, pkt_sent, payload_ready, crc_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] sb_q[$];
  logic pend = 0, pend_empty = 0;

  always #5 clk = ~clk;

  pkt_fifo_status uut (
    .clk, .rst, .wr_en, .wr_data, .rd_en, .rd_data, .level_thresh,
    .ovr_clr_wr, .ovr_clr_bit, .mode, .crc_check_en, .crc_autoclr_off,
    .tx_done_stb, .rx_last_stb, .crc_pass_stb, .full, .not_empty,
    .above_level, .overrun, .pkt_sent, .payload_ready, .crc_ok
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO check FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the expected byte after each read the design performed.
  always @(posedge clk) begin
    pend       <= rd_en;
    pend_empty <= (sb_q.size() == 0);
  end
  always @(negedge clk) begin
    if (pend) begin
      if (pend_empty) chk("R13 empty read data", int'(rd_data), 0);
      else            chk("R2 read order", int'(rd_data), int'(sb_q.pop_front()));
    end
  end

  task automatic push(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    if (sb_q.size() < DEPTH) sb_q.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pop();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic both(input logic [7:0] d);
    wr_en = 1; rd_en = 1; wr_data = d;
    sb_q.push_back(d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic clear_w1(input logic b);
    ovr_clr_wr = 1; ovr_clr_bit = b;
    if (b) sb_q.delete();
    @(negedge clk);
    ovr_clr_wr = 0; ovr_clr_bit = 0;
  endtask

  task automatic strobe(input logic tx, input logic last, input logic good);
    tx_done_stb = tx; rx_last_stb = last; crc_pass_stb = good;
    @(negedge clk);
    tx_done_stb = 0; rx_last_stb = 0; crc_pass_stb = 0;
  endtask

  initial begin
    #2_000_000;
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 not_empty", not_empty, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 payload_ready", payload_ready, 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R13 empty read returns zero and moves nothing
    pop();
    chk("R13 still empty", not_empty, 0);
    push(8'hA1);
    pop();
    chk("R13 read pointer unmoved", not_empty, 0);

    // R4, R5 threshold boundary (threshold 4)
    push(8'h11);
    chk("R4 not_empty after one", not_empty, 1);
    push(8'h12); push(8'h13); push(8'h14);
    chk("R5 equal to threshold", above_level, 0);
    push(8'h15);
    chk("R5 above threshold", above_level, 1);

    // R14 simultaneous read and write keep count at 5
    both(8'h16);
    chk("R14 count kept", above_level, 1);
    pop();
    chk("R14 count now 4", above_level, 0);
    repeat (4) pop();
    chk("R2 drained", not_empty, 0);

    // R3 fill to 66, R6 overrun, data intact
    for (int i = 0; i < DEPTH - 1; i++) push(8'(i * 3 + 1));
    chk("R3 full at 65", full, 0);
    push(8'hC3);
    chk("R3 full at 66", full, 1);
    push(8'hEE);
    chk("R6 overrun set", overrun, 1);
    chk("R6 still full", full, 1);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R6 drained after overrun", not_empty, 0);

    // R8 clear with bit 0 has no effect; bit 1 flushes
    clear_w1(1'b0);
    chk("R8 zero write keeps overrun", overrun, 1);
    push(8'h55); push(8'h56);
    clear_w1(1'b1);
    chk("R8 overrun cleared", overrun, 0);
    chk("R8 flushed", not_empty, 0);
    push(8'h57);
    pop();
    chk("R8 usable after flush", not_empty, 0);

    // R7 sleep mode: overflow write not flagged
    mode = 2'b00;
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    push(8'h99);
    chk("R7 no overrun in sleep", overrun, 0);
    chk("R7 full", full, 1);
    clear_w1(1'b1);

    // R9 packet sent
    mode = 2'b11;
    strobe(1, 0, 0);
    chk("R9 ignored outside tx", pkt_sent, 0);
    mode = 2'b10;
    strobe(1, 0, 0);
    chk("R9 set in tx", pkt_sent, 1);
    mode = 2'b01;
    @(negedge clk);
    chk("R9 cleared after leaving tx", pkt_sent, 0);

    // R10, R11, R12 receive flags
    mode = 2'b11;
    push(8'h21); push(8'h22);
    strobe(0, 1, 0);
    chk("R10 bad crc blocks ready", payload_ready, 0);
    chk("R11 no crc ok", crc_ok, 0);
    strobe(0, 1, 1);
    chk("R10 ready with good crc", payload_ready, 1);
    chk("R11 crc ok set", crc_ok, 1);
    pop();
    chk("R12 ready held with data", payload_ready, 1);
    pop();
    chk("R12 ready cleared on empty", payload_ready, 0);
    chk("R12 crc cleared on empty", crc_ok, 0);

    crc_check_en = 0;
    push(8'h31);
    strobe(0, 1, 0);
    chk("R10 crc disabled", payload_ready, 1);
    pop();
    crc_check_en = 1; crc_autoclr_off = 1;
    push(8'h32);
    strobe(0, 1, 0);
    chk("R10 autoclear off", payload_ready, 1);
    chk("R11 no crc ok without pass", crc_ok, 0);
    pop();
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule